// File: doc/BRIEF.md
# Sample-and-Convert Sequencer

This block controls the timing of one analog-to-digital converter channel. It runs on a free-running conversion clock. It raises a sample-enable line for the analog front end and then holds a conversion-busy flag for a number of clocks set by the selected resolution. When conversion ends it captures the converter's digital output into a result register and pulses a result-valid strobe for one cycle.

Three start modes are available. In continuous mode, sampling and converting repeat back to back while the block is enabled. In pulse mode, a one-cycle trigger opens a sample window of programmable length, and conversion follows. In gated mode, an external gate that may be asynchronous controls the window. Its rising edge opens the window and its falling edge closes it and starts conversion. The result therefore appears a fixed number of clocks after the gate falls, however long the gate stayed high.

The gate passes through a synchronizer before its edges are detected. A gate rising edge that arrives while a conversion is still running is dropped, and this sets a sticky overrun flag.

Top module: `sc_sequencer`

## Requirements
- R1: After reset, sampleEn, convBusy, resultValid and overrun are 0, and result is 0.
- R2: Conversion holds convBusy high for 13, 11 or 9 cycles when resolution is 2'b00 (12-bit), 2'b01 (10-bit) or 2'b10 (8-bit), respectively. Code 2'b11 behaves as 8-bit.
- R3: In pulse mode (mode 2'b01), a one-cycle trigPulse seen while idle and enabled opens a sample window of N cycles, followed directly by conversion. N is sampleCycles limited to the range 4 to 1024.
- R4: In continuous mode (mode 2'b00), while enable is high, a new sample window starts in the same cycle as each resultValid. Consecutive results are therefore N + conversion length cycles apart.
- R5: In gated mode (mode 2'b10), sampleEn stays high for exactly as many cycles as the synchronized gate stays high. Conversion starts in the cycle after the synchronized falling edge, so the result follows the fall of sampleEn by the conversion length, whatever the gate width.
- R6: resultValid is high for one cycle, in the cycle right after the last busy cycle. result then equals convData as it was in that last busy cycle, and it holds that value until the next conversion completes.
- R7: In gated mode, a synchronized gate rising edge seen during any busy cycle, including the last one, starts no sample and sets overrun. overrun stays set until reset.
- R8: A trigPulse that arrives during a sample window or a conversion has no effect.
- R9: sampleEn and convBusy are never high in the same cycle.
- R10: When enable is low, no new sample starts. A sample or conversion that is already running completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| enable | input | 1 | Allows new sample windows to start |
| mode | input | 2 | 00 continuous, 01 pulse, 10 gated |
| res | input | 2 | Resolution: 00 12-bit, 01 10-bit, 10 or 11 8-bit |
| sampleCycles | input | 11 | Timed sample window length in cycles (limited to 4 to 1024) |
| trigPulse | input | 1 | Pulse-mode start request, synchronous to clk |
| gateIn | input | 1 | Gate input for gated mode; may be asynchronous |
| convData | input | 12 | Digital output of the converter stub |
| sampleEn | output | 1 | Sample switch enable for the analog front end |
| convBusy | output | 1 | High while a conversion runs |
| resultValid | output | 1 | One-cycle strobe when a new result is stored |
| result | output | 12 | Last captured conversion result |
| overrun | output | 1 | Sticky flag for a gate edge dropped during conversion |

## Verification
The collision of interest is between completing a conversion and seeing a new gate rising edge. The bench times the gate so that its synchronized rising edge lands exactly on the last busy cycle, and it does the same with the edge a few cycles into the conversion. In both cases it expects exactly one result with the correct data and the correct busy length, overrun set, and no sample window opened afterwards. A scoreboard pairs each result with an expected data value, busy length, sample length and spacing, so any extra or missing result is reported.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    MODE_CONT  = 2'b00,
    MODE_PULSE = 2'b01,
    MODE_GATED = 2'b10
  } modeT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SAMP  = 2'b01,
    ST_GSAMP = 2'b10,
    ST_CONV  = 2'b11
  } stateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSample;
    logic loadConv;
    logic countDown;
    logic capture;
    logic flagOverrun;
  } strobeT;

  localparam int CONV_LEN_W = 5;

  // Conversion length in cycles for a resolution code
  function automatic logic [CONV_LEN_W-1:0] convLen(input logic [1:0] resCode);
    case (resCode)
      2'b00:   convLen = 5'd13;
      2'b01:   convLen = 5'd11;
      default: convLen = 5'd9;
    endcase
  endfunction

endpackage

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int WIN_W       = 11,
  parameter int WIN_MIN     = 4,
  parameter int WIN_MAX     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [1:0]        res,
  input  logic [WIN_W-1:0]  sampleCycles,
  input  logic              gateIn,
  input  logic [DATA_W-1:0] convData,
  output logic              cntZero,
  output logic              gateRise,
  output logic              gateFall,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              overrun
);

  localparam logic [WIN_W-1:0] WIN_LO = WIN_W'(WIN_MIN);
  localparam logic [WIN_W-1:0] WIN_HI = WIN_W'(WIN_MAX);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   gatePrev;
  logic                   gateLvl;
  logic [WIN_W-1:0]       cnt;
  logic [WIN_W-1:0]       winLen;
  logic [WIN_W-1:0]       convM1;

  // Gate synchronizer into the conversion-clock domain
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '0;
      gatePrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], gateIn};
      gatePrev <= gateLvl;
    end
  end

  assign gateLvl  = syncQ[SYNC_STAGES-1];
  assign gateRise = gateLvl & ~gatePrev;
  assign gateFall = ~gateLvl & gatePrev;

  // Sample window length, limited to the legal range
  always_comb begin
    if (sampleCycles < WIN_LO)      winLen = WIN_LO;
    else if (sampleCycles > WIN_HI) winLen = WIN_HI;
    else                            winLen = sampleCycles;
  end

  assign convM1 = WIN_W'(convLen(res) - 5'd1);

  // Shared down-counter for sample window and conversion
  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strb.loadSample) cnt <= winLen - WIN_W'(1);
    else if (strb.loadConv)   cnt <= convM1;
    else if (strb.countDown)  cnt <= cnt - WIN_W'(1);
  end

  assign cntZero = (cnt == '0);

  // Result register, valid strobe and sticky overrun flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      if (strb.capture)     result  <= convData;
      if (strb.flagOverrun) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/sc_control.sv
module sc_control
  import sc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       trigPulse,
  input  logic       cntZero,
  input  logic       gateRise,
  input  logic       gateFall,
  output strobeT     strb,
  output logic       sampleEn,
  output logic       convBusy
);

  stateT state, stateNext;
  modeT  modeSel;

  assign modeSel = modeT'(mode);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (enable) begin
          if (modeSel == MODE_CONT || (modeSel == MODE_PULSE && trigPulse)) begin
            strb.loadSample = 1'b1;
            stateNext       = ST_SAMP;
          end else if (modeSel == MODE_GATED && gateRise) begin
            stateNext = ST_GSAMP;
          end
        end
      end
      ST_SAMP: begin
        if (cntZero) begin
          strb.loadConv = 1'b1;
          stateNext     = ST_CONV;
        end else begin
          strb.countDown = 1'b1;
        end
      end
      ST_GSAMP: begin
        if (gateFall) begin
          strb.loadConv = 1'b1;
          stateNext     = ST_CONV;
        end
      end
      ST_CONV: begin
        if (modeSel == MODE_GATED && gateRise) strb.flagOverrun = 1'b1;
        if (cntZero) begin
          strb.capture = 1'b1;
          if (enable && modeSel == MODE_CONT) begin
            strb.loadSample = 1'b1;
            stateNext       = ST_SAMP;
          end else begin
            stateNext = ST_IDLE;
          end
        end else begin
          strb.countDown = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign sampleEn = (state == ST_SAMP) || (state == ST_GSAMP);
  assign convBusy = (state == ST_CONV);

endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import sc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int WIN_W       = 11,
  parameter int WIN_MIN     = 4,
  parameter int WIN_MAX     = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [1:0]        res,
  input  logic [WIN_W-1:0]  sampleCycles,
  input  logic              trigPulse,
  input  logic              gateIn,
  input  logic [DATA_W-1:0] convData,
  output logic              sampleEn,
  output logic              convBusy,
  output logic              resultValid,
  output logic [DATA_W-1:0] result,
  output logic              overrun
);

  strobeT strb;
  logic   cntZero;
  logic   gateRise;
  logic   gateFall;

  sc_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .mode      (mode),
    .trigPulse (trigPulse),
    .cntZero   (cntZero),
    .gateRise  (gateRise),
    .gateFall  (gateFall),
    .strb      (strb),
    .sampleEn  (sampleEn),
    .convBusy  (convBusy)
  );

  sc_datapath #(
    .DATA_W      (DATA_W),
    .WIN_W       (WIN_W),
    .WIN_MIN     (WIN_MIN),
    .WIN_MAX     (WIN_MAX),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .res          (res),
    .sampleCycles (sampleCycles),
    .gateIn       (gateIn),
    .convData     (convData),
    .cntZero      (cntZero),
    .gateRise     (gateRise),
    .gateFall     (gateFall),
    .result       (result),
    .resultValid  (resultValid),
    .overrun      (overrun)
  );

endmodule

// File: rtl/sc_sequencer_chk.sv
module sc_sequencer_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleEn,
  input logic              convBusy,
  input logic              resultValid,
  input logic [DATA_W-1:0] result,
  input logic              overrun
);

  // R9: sample window and conversion are exclusive
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEn && convBusy));

  // R6: the valid strobe lasts one cycle
  p_rv_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R6: a result follows a busy cycle
  p_rv_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(convBusy));

  // R6: result holds between completions
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));

  // R7: overrun is sticky
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);

  // R5: conversion only begins straight out of a sample window
  p_conv_after_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convBusy) |-> $past(sampleEn));

  // R5: closing a sample window starts conversion
  p_sample_to_conv_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleEn) |-> convBusy);

endmodule

bind sc_sequencer sc_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sampleEn    (sampleEn),
  .convBusy    (convBusy),
  .resultValid (resultValid),
  .result      (result),
  .overrun     (overrun)
);

// File: tb/sim_sc_sequencer.sv
`timescale 1ns/1ps
module sim_sc_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  res = 2'b00;
  logic [10:0] sampleCycles = 11'd4;
  logic        trigPulse = 1'b0;
  logic        gateIn = 1'b0;
  logic [11:0] convData = 12'h000;
  logic        sampleEn, convBusy, resultValid, overrun;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;
  int rvCount = 0;
  bit done = 1'b0;

  // Scoreboard queues: data, busy length, sample length (0 = skip), spacing (0 = skip)
  int qD[$];
  int qL[$];
  int qN[$];
  int qG[$];

  always #2.5 clk = ~clk;

  sc_sequencer u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .res(res),
    .sampleCycles(sampleCycles), .trigPulse(trigPulse), .gateIn(gateIn),
    .convData(convData), .sampleEn(sampleEn), .convBusy(convBusy),
    .resultValid(resultValid), .result(result), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int d, input int l, input int n, input int g);
    qD.push_back(d); qL.push_back(l); qN.push_back(n); qG.push_back(g);
  endtask

  // Monitor
  int  sRun = 0, bRun = 0, lastS = 0, lastB = 0, cyc = 0, lastV = -1;
  bit  prevRv = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      sRun = 0; bRun = 0; lastS = 0; lastB = 0; lastV = -1; prevRv = 1'b0;
    end else begin
      cyc++;
      if (sampleEn && convBusy) chk(1'b0, "R9", "sample and busy overlap", 1, 0);
      if (!sampleEn && sRun > 0) begin lastS = sRun; sRun = 0; end
      if (!convBusy && bRun > 0) begin lastB = bRun; bRun = 0; end
      if (sampleEn) sRun++;
      if (convBusy) bRun++;
      if (prevRv && resultValid) chk(1'b0, "R6", "valid longer than one cycle", 2, 1);
      if (resultValid) begin
        rvCount++;
        if (qD.size() == 0) begin
          chk(1'b0, "R7/R8", "unexpected result", rvCount, rvCount - 1);
        end else begin
          int d, l, n, g;
          d = qD.pop_front(); l = qL.pop_front(); n = qN.pop_front(); g = qG.pop_front();
          chk(int'(result) == d, "R6", "result data", int'(result), d);
          chk(lastB == l, "R2", "busy length", lastB, l);
          if (n != 0) chk(lastS == n, "R3/R5", "sample length", lastS, n);
          if (g != 0) chk((cyc - lastV) == g, "R4", "result spacing", cyc - lastV, g);
        end
        lastV = cyc;
      end
      prevRv = resultValid;
    end
  end

  task automatic doReset();
    rstN = 1'b0; enable = 1'b0; gateIn = 1'b0; trigPulse = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic pulse();
    @(posedge clk); #1 trigPulse = 1'b1;
    @(posedge clk); #1 trigPulse = 1'b0;
  endtask

  task automatic gatePulse(input int w);
    @(posedge clk); #1 gateIn = 1'b1;
    repeat (w) @(posedge clk);
    #1 gateIn = 1'b0;
  endtask

  task automatic waitCount(input int n);
    wait (rvCount >= n);
    repeat (3) @(posedge clk);
  endtask

  task automatic waitBusy();
    @(negedge clk);
    while (!convBusy) @(negedge clk);
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish();
    end
  end

  initial begin
    int base;
    doReset();
    @(negedge clk);
    // R1 reset state
    chk(!sampleEn && !convBusy && !resultValid, "R1", "control outputs after reset",
        int'({sampleEn, convBusy, resultValid}), 0);
    chk(result == 12'h000 && !overrun, "R1", "result and overrun after reset",
        int'(result) + int'(overrun), 0);

    // R3/R2: pulse mode, window below minimum, 12-bit
    enable = 1'b1; mode = 2'b01; res = 2'b00; sampleCycles = 11'd2; convData = 12'hA5C;
    push(12'hA5C, 13, 4, 0); base = rvCount;
    pulse(); waitCount(base + 1);
    // R6: result holds after convData changes
    convData = 12'h123; repeat (20) @(posedge clk); @(negedge clk);
    chk(result == 12'hA5C, "R6", "result held", int'(result), 12'hA5C);

    // R3/R2: 10-bit, mid window
    res = 2'b01; sampleCycles = 11'd37; convData = 12'h3C1;
    push(12'h3C1, 11, 37, 0); base = rvCount;
    pulse(); waitCount(base + 1);

    // R3/R2: 8-bit via code 11, window above maximum
    res = 2'b11; sampleCycles = 11'd2000; convData = 12'hFFF;
    push(12'hFFF, 9, 1024, 0); base = rvCount;
    pulse(); waitCount(base + 1);

    // R8: triggers during sample and conversion are ignored
    res = 2'b00; sampleCycles = 11'd4; convData = 12'h0F0;
    push(12'h0F0, 13, 4, 0); base = rvCount;
    pulse(); pulse(); waitBusy(); pulse();
    waitCount(base + 1); repeat (30) @(posedge clk); @(negedge clk);
    chk(rvCount == base + 1, "R8", "result count after ignored triggers", rvCount, base + 1);
    chk(!sampleEn && !convBusy, "R8", "idle after ignored triggers", int'(sampleEn), 0);

    // R4/R10: continuous mode, then disable mid-run
    enable = 1'b0; mode = 2'b00; res = 2'b10; sampleCycles = 11'd4; convData = 12'h5A5;
    @(posedge clk);
    push(12'h5A5, 9, 4, 0); push(12'h5A5, 9, 4, 13); push(12'h5A5, 9, 4, 13);
    base = rvCount;
    #1 enable = 1'b1;
    wait (rvCount == base + 2);
    @(posedge clk); #1 enable = 1'b0;
    repeat (40) @(posedge clk); @(negedge clk);
    chk(rvCount == base + 3, "R10", "results after disable", rvCount, base + 3);
    chk(!sampleEn && !convBusy, "R10", "no new sample when disabled", int'(sampleEn), 0);

    // R5: gated mode, two gate widths, 12-bit
    enable = 1'b1; mode = 2'b10; res = 2'b00; convData = 12'h777;
    push(12'h777, 13, 10, 0); base = rvCount;
    gatePulse(10); waitCount(base + 1);
    convData = 12'h888;
    push(12'h888, 13, 40, 0); base = rvCount;
    gatePulse(40); waitCount(base + 1);
    chk(!overrun, "R7", "no overrun from clean gating", int'(overrun), 0);

    // R7: gate edge early in conversion
    doReset();
    enable = 1'b1; mode = 2'b10; res = 2'b00; convData = 12'h246;
    push(12'h246, 13, 6, 0); base = rvCount;
    gatePulse(6); waitBusy();
    repeat (2) @(posedge clk); #1 gateIn = 1'b1;
    repeat (30) @(posedge clk); #1 gateIn = 1'b0;
    repeat (20) @(posedge clk); @(negedge clk);
    chk(overrun, "R7", "overrun set mid conversion", int'(overrun), 1);
    chk(rvCount == base + 1, "R7", "edge during conversion ignored", rvCount, base + 1);

    // R7: gate edge on the last busy cycle, same cycle as completion
    doReset();
    @(negedge clk);
    chk(!overrun, "R1", "overrun cleared by reset", int'(overrun), 0);
    enable = 1'b1; mode = 2'b10; res = 2'b10; convData = 12'h9AB;
    push(12'h9AB, 9, 6, 0); base = rvCount;
    gatePulse(6); waitBusy();
    repeat (6) @(posedge clk); #1 gateIn = 1'b1;
    repeat (20) @(posedge clk); @(negedge clk);
    chk(overrun, "R7", "overrun set on last busy cycle", int'(overrun), 1);
    chk(!sampleEn, "R7", "no sample from dropped edge", int'(sampleEn), 0);
    chk(rvCount == base + 1, "R7", "single result at collision", rvCount, base + 1);
    #1 gateIn = 1'b0;
    repeat (10) @(posedge clk);

    chk(qD.size() == 0, "R6", "pending expected results", qD.size(), 0);
    done = 1'b1;
    finish();
  end

endmodule